// File: doc/BRIEF.md
# Wide Integer Execution Unit

This block is the arithmetic stage of a wide-word datapath for multi-precision cryptographic code. Each clock it takes two unsigned 128-bit operands, an opcode, a carry input and a shift amount. One cycle later it returns a 128-bit result, a carry flag and three magnitude flags. It covers addition with and without carry-in, subtraction, unsigned comparison, and logical shifts in both directions.

The adder splits each operand at bit 64. One 64-bit ripple adder sums the lower halves. Two more 64-bit ripple adders sum the upper halves at the same time, one assuming an incoming carry of 0 and one assuming 1. The carry out of the lower half then picks the right upper sum. The path is one 64-bit ripple plus a multiplexer rather than a 128-bit ripple. Subtraction reuses this adder: the second operand is inverted and the low carry-in is forced high. The shifter is a logarithmic stage network, and right shifts run through it by mirroring the bit order.

Top module: `wide_int_exu`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero at that edge.
- R2: Outputs are registered. Inputs presented before a rising edge appear at the outputs after that edge and not before it.
- R3: Opcode 0 (add) gives `{out_carry, out_res}` equal to the 129-bit sum of `in_a` and `in_b`; `in_cin` is ignored.
- R4: Opcode 1 (add with carry) gives `{out_carry, out_res}` equal to `in_a + in_b + in_cin`.
- R5: Opcode 2 (subtract) gives `out_res = in_a - in_b` modulo 2^128, with `out_carry` high exactly when `in_a >= in_b` (carry means no borrow).
- R6: A carry or borrow produced in bits 63..0 reaches bits 127..64 correctly, including chains that run through all 128 bits.
- R7: Opcode 3 (compare) raises exactly one of `out_eq`, `out_lt`, `out_gt`, set from the unsigned comparison of `in_a` with `in_b`; `out_res` and `out_carry` are zero.
- R8: Opcode 4 (shift left) gives `in_a << in_shamt` with zero fill for amounts 0 to 127; `out_carry` is zero.
- R9: Opcode 5 (shift right) gives `in_a >> in_shamt` with zero fill for amounts 0 to 127; `out_carry` is zero.
- R10: Opcodes 6 and 7 give all outputs zero.
- R11: For every opcode other than 3, the three magnitude flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_op | input | 3 | Operation select (0 add, 1 add-carry, 2 subtract, 3 compare, 4 shift left, 5 shift right) |
| in_a | input | 128 | First operand; the value that is shifted |
| in_b | input | 128 | Second operand |
| in_cin | input | 1 | Carry input used by opcode 1 |
| in_shamt | input | 7 | Shift distance |
| out_res | output | 128 | Registered result |
| out_carry | output | 1 | Carry out of add, not-borrow of subtract |
| out_eq | output | 1 | Operands equal (compare only) |
| out_lt | output | 1 | First operand below second (compare only) |
| out_gt | output | 1 | First operand above second (compare only) |

## Verification
The bench puts carries across bit 64 in both directions. If the select multiplexer were wired backwards or took the wrong upper sum, the upper half would come out off by one. It also runs a full 128-bit wrap, where a dropped final carry would clear `out_carry`. Compare vectors place the only difference in the upper half, or make the halves disagree in direction. A comparator that let the low half dominate would then raise the wrong flag. Shifts of 0, 1, 64 and 127 catch a stage wired to the wrong distance, and unused opcodes catch a result that leaks through.

// File: rtl/wexu_pkg.sv
package wexu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5
  } wexu_op_e;

endpackage

// File: rtl/wexu_ripple.sv
module wexu_ripple #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]      = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1]  = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign cout = chain[W];

endmodule

// File: rtl/wexu_csel_adder.sv
module wexu_csel_adder #(
  parameter int W = 128,
  localparam int H = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [H-1:0] lo_sum, hi_sum0, hi_sum1;
  logic         lo_c, hi_c0, hi_c1;

  wexu_ripple #(.W(H)) u_lo (
    .a(a[H-1:0]), .b(b[H-1:0]), .cin(cin), .sum(lo_sum), .cout(lo_c)
  );

  wexu_ripple #(.W(H)) u_hi0 (
    .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b0), .sum(hi_sum0), .cout(hi_c0)
  );

  wexu_ripple #(.W(H)) u_hi1 (
    .a(a[W-1:H]), .b(b[W-1:H]), .cin(1'b1), .sum(hi_sum1), .cout(hi_c1)
  );

  // Low-half carry chooses the precomputed upper sum.
  assign sum  = {(lo_c ? hi_sum1 : hi_sum0), lo_sum};
  assign cout = lo_c ? hi_c1 : hi_c0;

endmodule

// File: rtl/wexu_compare.sv
module wexu_compare #(
  parameter int W = 128,
  localparam int H = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt,
  output logic         gt
);

  logic hi_eq, hi_lt, lo_eq, lo_lt;

  assign hi_eq = (a[W-1:H] == b[W-1:H]);
  assign hi_lt = (a[W-1:H] <  b[W-1:H]);
  assign lo_eq = (a[H-1:0] == b[H-1:0]);
  assign lo_lt = (a[H-1:0] <  b[H-1:0]);

  // Upper half decides unless it ties.
  assign eq = hi_eq & lo_eq;
  assign lt = hi_lt | (hi_eq & lo_lt);
  assign gt = ~eq & ~lt;

endmodule

// File: rtl/wexu_shifter.sv
module wexu_shifter #(
  parameter int W = 128,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] amt,
  input  logic          right,
  output logic [W-1:0]  result
);

  logic [W-1:0] mirrored;
  logic [W-1:0] stage [SW+1];

  // Right shifts are done as left shifts on the bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_in
    assign mirrored[i] = right ? data[W-1-i] : data[i];
  end

  assign stage[0] = mirrored;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    assign result[i] = right ? stage[SW][W-1-i] : stage[SW][i];
  end

endmodule

// File: rtl/wide_int_exu.sv
module wide_int_exu
  import wexu_pkg::*;
#(
  parameter int WIDTH = 128,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_cin,
  input  logic [SHW-1:0]   in_shamt,
  output logic [WIDTH-1:0] out_res,
  output logic             out_carry,
  output logic             out_eq,
  output logic             out_lt,
  output logic             out_gt
);

  logic [WIDTH-1:0] add_b, add_sum, sh_res, nxt_res;
  logic             add_cin, add_cout, nxt_carry;
  logic             cmp_eq, cmp_lt, cmp_gt;
  logic             nxt_eq, nxt_lt, nxt_gt;
  logic             primed;

  // Subtract = add of inverted operand with carry-in forced high.
  assign add_b   = (in_op == OP_SUB) ? ~in_b : in_b;
  assign add_cin = (in_op == OP_SUB) | ((in_op == OP_ADC) & in_cin);

  wexu_csel_adder #(.W(WIDTH)) u_add (
    .a(in_a), .b(add_b), .cin(add_cin), .sum(add_sum), .cout(add_cout)
  );

  wexu_compare #(.W(WIDTH)) u_cmp (
    .a(in_a), .b(in_b), .eq(cmp_eq), .lt(cmp_lt), .gt(cmp_gt)
  );

  wexu_shifter #(.W(WIDTH)) u_sh (
    .data(in_a), .amt(in_shamt), .right(in_op == OP_SHR), .result(sh_res)
  );

  always_comb begin
    nxt_res   = '0;
    nxt_carry = 1'b0;
    nxt_eq    = 1'b0;
    nxt_lt    = 1'b0;
    nxt_gt    = 1'b0;
    case (in_op)
      OP_ADD, OP_ADC, OP_SUB: begin
        nxt_res   = add_sum;
        nxt_carry = add_cout;
      end
      OP_CMP: begin
        nxt_eq = cmp_eq;
        nxt_lt = cmp_lt;
        nxt_gt = cmp_gt;
      end
      OP_SHL, OP_SHR: nxt_res = sh_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_res   <= '0;
      out_carry <= 1'b0;
      out_eq    <= 1'b0;
      out_lt    <= 1'b0;
      out_gt    <= 1'b0;
      primed    <= 1'b0;
    end else begin
      out_res   <= nxt_res;
      out_carry <= nxt_carry;
      out_eq    <= nxt_eq;
      out_lt    <= nxt_lt;
      out_gt    <= nxt_gt;
      primed    <= 1'b1;
    end
  end

  // Output register checks against wide arithmetic on the sampled inputs.
  a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) == OP_ADD |->
      {out_carry, out_res} == ({1'b0, $past(in_a)} + {1'b0, $past(in_b)}));

  a_r5_sub_borrow: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) == OP_SUB |->
      out_res == ($past(in_a) - $past(in_b)) &&
      out_carry == ($past(in_a) >= $past(in_b)));

  a_r7_cmp_onehot: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) == OP_CMP |->
      $countones({out_eq, out_lt, out_gt}) == 1 && out_res == '0);

  a_r11_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) != OP_CMP |-> !out_eq && !out_lt && !out_gt);

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) > 3'd5 |-> out_res == '0 && !out_carry);

  a_r8_shl_value: assert property (@(posedge clk) disable iff (rst)
    primed && $past(in_op) == OP_SHL |->
      out_res == ($past(in_a) << $past(in_shamt)) && !out_carry);

endmodule

// File: tb/wide_int_exu_tb.sv
module wide_int_exu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic [2:0]   op;
    logic [127:0] a;
    logic [127:0] b;
    logic         cin;
    logic [6:0]   sh;
  } vec_t;

  typedef struct packed {
    logic [127:0] res;
    logic         carry;
    logic         eq;
    logic         lt;
    logic         gt;
  } exp_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 128'd5, 128'd7, 1'b1, 7'd0},                        // R3 cin ignored
    '{3'd0, {64'd0, ONES}, 128'd1, 1'b0, 7'd0},                 // R6 carry into bit 64
    '{3'd0, {ONES, ONES}, 128'd1, 1'b0, 7'd0},                  // R6 full wrap
    '{3'd1, {64'd0, ONES}, 128'd0, 1'b1, 7'd0},                 // R4 cin ripples up
    '{3'd1, {64'h1234, 64'h8000_0000_0000_0000}, {64'h1, 64'h8000_0000_0000_0001}, 1'b0, 7'd0}, // R4
    '{3'd2, {64'hA5A5, 64'h5A5A}, {64'hA5A5, 64'h5A5A}, 1'b0, 7'd0}, // R5 equal
    '{3'd2, 128'd1, 128'd2, 1'b0, 7'd0},                        // R5 borrow wraps
    '{3'd2, {64'd1, 64'd0}, 128'd1, 1'b0, 7'd0},                // R6 borrow from upper
    '{3'd3, {64'h77, 64'h99}, {64'h77, 64'h99}, 1'b0, 7'd0},    // R7 eq
    '{3'd3, {64'h1, 64'h0}, {64'h2, 64'h0}, 1'b0, 7'd0},        // R7 lt upper
    '{3'd3, {64'h5, 64'h9}, {64'h5, 64'h3}, 1'b0, 7'd0},        // R7 gt lower
    '{3'd3, {64'h2, 64'h0}, {64'h1, ONES}, 1'b0, 7'd0},         // R7 halves disagree
    '{3'd4, {64'hDEAD, 64'hBEEF}, 128'd0, 1'b0, 7'd0},          // R8 zero shift
    '{3'd4, {64'hDEAD, 64'hBEEF}, 128'd0, 1'b0, 7'd64},         // R8
    '{3'd4, {ONES, ONES}, 128'd0, 1'b0, 7'd127},                // R8
    '{3'd5, {64'h8000_0000_0000_0000, 64'h3}, 128'd0, 1'b0, 7'd1}, // R9
    '{3'd5, {ONES, ONES}, 128'd0, 1'b0, 7'd127},                // R9
    '{3'd5, {64'hCAFE, 64'hF00D}, 128'd0, 1'b0, 7'd64},         // R9
    '{3'd6, {ONES, ONES}, {ONES, ONES}, 1'b1, 7'd3},            // R10
    '{3'd7, 128'd9, 128'd4, 1'b1, 7'd5}                         // R10
  };

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   in_op;
  logic [127:0] in_a, in_b;
  logic         in_cin;
  logic [6:0]   in_shamt;
  logic [127:0] out_res;
  logic         out_carry, out_eq, out_lt, out_gt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wide_int_exu u_dut (
    .clk(clk), .rst(rst), .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .in_shamt(in_shamt), .out_res(out_res),
    .out_carry(out_carry), .out_eq(out_eq), .out_lt(out_lt), .out_gt(out_gt)
  );

  function automatic exp_t model(vec_t v);
    exp_t e = '0;
    logic [128:0] w;
    case (v.op)
      3'd0: begin w = {1'b0, v.a} + {1'b0, v.b}; e.res = w[127:0]; e.carry = w[128]; end
      3'd1: begin w = {1'b0, v.a} + {1'b0, v.b} + 129'(v.cin); e.res = w[127:0]; e.carry = w[128]; end
      3'd2: begin e.res = v.a - v.b; e.carry = (v.a >= v.b); end
      3'd3: begin e.eq = (v.a == v.b); e.lt = (v.a < v.b); e.gt = (v.a > v.b); end
      3'd4: e.res = v.a << v.sh;
      3'd5: e.res = v.a >> v.sh;
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3/R6/R11";
      3'd1: return "R4/R6/R11";
      3'd2: return "R5/R6/R11";
      3'd3: return "R7";
      3'd4: return "R8/R11";
      3'd5: return "R9/R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, exp_t exp);
    exp_t act;
    act = '{out_res, out_carry, out_eq, out_lt, out_gt};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual res=%h c=%b eq/lt/gt=%b%b%b expected res=%h c=%b eq/lt/gt=%b%b%b",
               tag, act.res, act.carry, act.eq, act.lt, act.gt,
               exp.res, exp.carry, exp.eq, exp.lt, exp.gt);
    end
  endtask

  task automatic drive(vec_t v);
    in_op = v.op; in_a = v.a; in_b = v.b; in_cin = v.cin; in_shamt = v.sh;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    check("R1 reset clears outputs", '0);

    // R2: result must not appear before the capturing edge.
    rst = 1'b0;
    drive(VECS[0]);
    #(CLK_PERIOD / 2 - 1);
    check("R2 held before edge", '0);
    @(negedge clk);
    check("R2 after one edge", model(VECS[0]));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check(tag_of(VECS[i].op), model(VECS[i]));
    end

    // R1: reset in the middle of work wipes a nonzero result.
    drive(VECS[2]);
    @(negedge clk);
    check("R6 wrap before reset", model(VECS[2]));
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", '0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule